// File: doc/BRIEF.md
# Oversampled UART Character Framer

This block converts between parallel bytes and an asynchronous serial line. It runs on a tick clock at eight times the bit rate, so every bit on the line lasts eight clock cycles. On the transmit side it takes one byte at a time through a ready/valid port. It drives a low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits. The line then goes back to its high idle level.

The receive side watches the line for a falling edge and confirms the start bit halfway through the bit. It samples every later bit once, at its centre tick, and rebuilds the character. It then presents the byte for one cycle, together with parity, framing and break flags for that character. A small set of static configuration inputs selects the enable, the character length, the stop bits, the parity kind and internal loopback. Another input forces a break on the transmit line. Queueing, registers and interrupts are left to the logic around the block.

Top module: `uart_framer`

## Requirements
- R1: After a byte is accepted (`tx_valid` and `tx_ready` high at a clock edge), `tx_ready` drops. `txd` then carries a low start bit, the data bits LSB first, an optional parity bit and high stop bit(s), each lasting 8 cycles. The line then stays high, and `tx_ready` returns exactly 8 x (frame bits) cycles after the accepting edge.
- R2: `cfg_eight_bits` = 1 selects 8 data bits and 0 selects 7. In 7-bit mode, bit 7 of `tx_data` is not sent and bit 7 of `rx_data` reads 0.
- R3: When `cfg_par_en` = 1, a parity bit follows the data. `cfg_par_mode` selects it: 0 odd (data plus parity has an odd count of ones), 1 even, 2 always 0, 3 always 1.
- R4: `cfg_two_stop` = 1 makes the transmitter send two stop bits. The receiver always checks only one stop bit.
- R5: The receiver samples each bit at tick 4 of its 8-tick period and rebuilds the byte. It raises `rx_valid` for exactly one cycle per character, at the middle of the stop bit.
- R6: A low pulse that ends before the middle of the start bit is dropped as a glitch, and no character is produced.
- R7: `rx_par_err` is set with a character when parity is enabled and the received parity bit differs from the value that R3 requires.
- R8: `rx_frm_err` is set with a character whose stop bit is sampled low.
- R9: `rx_brk` is set when every data bit, the parity bit (if enabled) and the stop bit are all sampled low. Such a character also has `rx_frm_err` set and `rx_data` = 0.
- R10: With `cfg_loop` = 1, the transmit serial stream feeds the receiver in place of `rxd`, and the `txd` pin stays high.
- R11: While `cfg_brk_req` = 1, `txd` is held low. `txd` goes back to normal when the request is released.
- R12: With `cfg_enable` = 0, `tx_ready` is low, `txd` is high and the receiver produces no characters from `rxd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, 8x the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Framer enable |
| cfg_eight_bits | input | 1 | 1 = 8 data bits, 0 = 7 |
| cfg_two_stop | input | 1 | Two transmit stop bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_mode | input | 2 | 0 odd, 1 even, 2 space, 3 mark |
| cfg_loop | input | 1 | Internal loopback |
| cfg_brk_req | input | 1 | Hold transmit line low |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Transmitter can accept a byte |
| txd | output | 1 | Serial output pin |
| rxd | input | 1 | Serial input pin (asynchronous) |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle character strobe |
| rx_par_err | output | 1 | Parity mismatch for this character |
| rx_frm_err | output | 1 | Stop bit sampled low |
| rx_brk | output | 1 | Whole character sampled low |

## Verification
The hardest cases to reach from the ports are the receiver's error corners. These are a start pulse that vanishes before mid-bit, a parity bit that disagrees with its mode, and a line held low through a whole character. The transmitter cannot produce any of them. So the bench bit-bangs `rxd` directly, eight cycles per bit. It corrupts the parity or stop bit on purpose, holds the line low for a full frame to create a break, and sends a two-cycle low pulse as a glitch. Each mode is also sent through loopback, so that transmit and receive framing are checked against each other.

// File: rtl/uart_fr_pkg.sv
package uart_fr_pkg;

    localparam int OVS      = 8;            // sample ticks per bit
    localparam int DW       = 8;            // widest character
    localparam int MID_TICK = OVS / 2;      // centre sample position

    typedef enum logic [1:0] {
        PAR_ODD   = 2'd0,
        PAR_EVEN  = 2'd1,
        PAR_SPACE = 2'd2,
        PAR_MARK  = 2'd3
    } par_mode_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP
    } phase_e;

    typedef struct packed {
        logic      enable;
        logic      eight;
        logic      two_stop;
        logic      par_en;
        par_mode_e par_mode;
    } frame_cfg_t;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          par_err;
        logic          frm_err;
        logic          brk;
    } rx_char_t;

    // Parity bit demanded by the mode for a character (7-bit mode masks bit 7).
    function automatic logic parity_bit(input logic [DW-1:0] d, input logic eight,
                                        input par_mode_e m);
        logic x;
        x = ^(eight ? d : {1'b0, d[DW-2:0]});
        case (m)
            PAR_ODD:   return ~x;
            PAR_EVEN:  return x;
            PAR_SPACE: return 1'b0;
            default:   return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/uart_fr_tx.sv
module uart_fr_tx
    import uart_fr_pkg::*;
#(
    parameter int OVS_P = OVS
) (
    input  logic          clk,
    input  logic          rst,
    input  frame_cfg_t    cfg,
    input  logic [DW-1:0] data,
    input  logic          valid,
    output logic          ready,
    output logic          line
);
    localparam int TW = $clog2(OVS_P);
    localparam int BW = $clog2(DW + 1);

    phase_e          ph;
    logic [TW-1:0]   tick;
    logic [BW-1:0]   bitn;
    logic [DW-1:0]   sh;
    logic            par_q;
    logic            last_tick;
    logic [BW-1:0]   nbits;

    assign last_tick = (tick == TW'(OVS_P - 1));
    assign nbits     = cfg.eight ? BW'(DW) : BW'(DW - 1);
    assign ready     = cfg.enable && (ph == PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst || !cfg.enable) begin
            ph    <= PH_IDLE;
            tick  <= '0;
            bitn  <= '0;
            sh    <= '0;
            par_q <= 1'b0;
        end else if (ph == PH_IDLE) begin
            if (valid) begin
                ph    <= PH_START;
                tick  <= '0;
                sh    <= data;
                par_q <= parity_bit(data, cfg.eight, cfg.par_mode);
            end
        end else begin
            tick <= tick + 1'b1;
            if (last_tick) begin
                tick <= '0;
                case (ph)
                    PH_START: begin
                        ph   <= PH_DATA;
                        bitn <= '0;
                    end
                    PH_DATA: begin
                        sh   <= sh >> 1;
                        bitn <= bitn + 1'b1;
                        if (bitn == nbits - 1'b1) begin
                            ph   <= cfg.par_en ? PH_PAR : PH_STOP;
                            bitn <= '0;
                        end
                    end
                    PH_PAR: begin
                        ph   <= PH_STOP;
                        bitn <= '0;
                    end
                    default: begin
                        if (cfg.two_stop && bitn == '0) bitn <= 1'b1;
                        else                           ph   <= PH_IDLE;
                    end
                endcase
            end
        end
    end

    always_comb begin
        case (ph)
            PH_START: line = 1'b0;
            PH_DATA:  line = sh[0];
            PH_PAR:   line = par_q;
            default:  line = 1'b1;
        endcase
    end

    assert_accept_drops_ready_R1: assert property (@(posedge clk) disable iff (rst)
        (valid && ready) |=> !ready);

    assert_start_low_R1: assert property (@(posedge clk) disable iff (rst)
        (valid && ready) |=> !line);

endmodule

// File: rtl/uart_fr_rx.sv
module uart_fr_rx
    import uart_fr_pkg::*;
#(
    parameter int OVS_P = OVS
) (
    input  logic       clk,
    input  logic       rst,
    input  frame_cfg_t cfg,
    input  logic       line,
    output rx_char_t   chr,
    output logic       valid
);
    localparam int TW = $clog2(OVS_P);
    localparam int BW = $clog2(DW + 1);

    phase_e          ph;
    logic [TW-1:0]   tick;
    logic [BW-1:0]   bitn;
    logic [DW-1:0]   sh;
    logic            prev;
    logic            all_low;
    logic            par_rx;
    logic            mid, last_tick;
    logic [BW-1:0]   nbits;
    logic [DW-1:0]   data_asm;

    assign mid       = (tick == TW'(MID_TICK));
    assign last_tick = (tick == TW'(OVS_P - 1));
    assign nbits     = cfg.eight ? BW'(DW) : BW'(DW - 1);
    assign data_asm  = cfg.eight ? sh : {1'b0, sh[DW-1:1]};

    always_ff @(posedge clk) begin
        if (rst || !cfg.enable) begin
            ph      <= PH_IDLE;
            tick    <= '0;
            bitn    <= '0;
            sh      <= '0;
            prev    <= 1'b1;
            all_low <= 1'b0;
            par_rx  <= 1'b0;
            valid   <= 1'b0;
            chr     <= '0;
        end else begin
            valid <= 1'b0;
            prev  <= line;
            if (ph == PH_IDLE) begin
                if (prev && !line) begin
                    ph   <= PH_START;
                    tick <= TW'(1);
                end
            end else begin
                tick <= tick + 1'b1;
                case (ph)
                    PH_START: begin
                        if (mid && line) ph <= PH_IDLE;
                        else if (last_tick) begin
                            ph      <= PH_DATA;
                            bitn    <= '0;
                            all_low <= 1'b1;
                        end
                    end
                    PH_DATA: begin
                        if (mid) begin
                            sh      <= {line, sh[DW-1:1]};
                            all_low <= all_low & ~line;
                        end
                        if (last_tick) begin
                            bitn <= bitn + 1'b1;
                            if (bitn == nbits - 1'b1)
                                ph <= cfg.par_en ? PH_PAR : PH_STOP;
                        end
                    end
                    PH_PAR: begin
                        if (mid) begin
                            par_rx  <= line;
                            all_low <= all_low & ~line;
                        end
                        if (last_tick) ph <= PH_STOP;
                    end
                    default: begin
                        if (mid) begin
                            ph          <= PH_IDLE;
                            valid       <= 1'b1;
                            chr.data    <= data_asm;
                            chr.par_err <= cfg.par_en &&
                                (par_rx != parity_bit(data_asm, cfg.eight, cfg.par_mode));
                            chr.frm_err <= !line;
                            chr.brk     <= all_low && !line;
                        end
                    end
                endcase
            end
        end
    end

    assert_single_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    assert_break_frames_R9: assert property (@(posedge clk) disable iff (rst)
        (valid && chr.brk) |-> chr.frm_err);

    assert_break_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (valid && chr.brk) |-> (chr.data == '0));

    assert_disabled_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        !cfg.enable |=> !valid);

endmodule

// File: rtl/uart_framer.sv
module uart_framer
    import uart_fr_pkg::*;
#(
    parameter int OVS_P = OVS
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_enable,
    input  logic        cfg_eight_bits,
    input  logic        cfg_two_stop,
    input  logic        cfg_par_en,
    input  logic [1:0]  cfg_par_mode,
    input  logic        cfg_loop,
    input  logic        cfg_brk_req,
    input  logic [7:0]  tx_data,
    input  logic        tx_valid,
    output logic        tx_ready,
    output logic        txd,
    input  logic        rxd,
    output logic [7:0]  rx_data,
    output logic        rx_valid,
    output logic        rx_par_err,
    output logic        rx_frm_err,
    output logic        rx_brk
);
    frame_cfg_t cfg;
    rx_char_t   chr;
    logic       tx_line, tx_stream;
    logic [1:0] rxd_sync;
    logic       rx_line;

    assign cfg = '{enable:   cfg_enable,
                   eight:    cfg_eight_bits,
                   two_stop: cfg_two_stop,
                   par_en:   cfg_par_en,
                   par_mode: par_mode_e'(cfg_par_mode)};

    // Two-stage synchroniser for the asynchronous pin.
    always_ff @(posedge clk) begin
        if (rst) rxd_sync <= 2'b11;
        else     rxd_sync <= {rxd_sync[0], rxd};
    end

    uart_fr_tx #(.OVS_P(OVS_P)) u_tx (
        .clk   (clk),
        .rst   (rst),
        .cfg   (cfg),
        .data  (tx_data),
        .valid (tx_valid),
        .ready (tx_ready),
        .line  (tx_line)
    );

    assign tx_stream = cfg_brk_req ? 1'b0 : tx_line;
    assign txd       = cfg_loop ? 1'b1 : tx_stream;
    assign rx_line   = cfg_loop ? tx_stream : rxd_sync[1];

    uart_fr_rx #(.OVS_P(OVS_P)) u_rx (
        .clk   (clk),
        .rst   (rst),
        .cfg   (cfg),
        .line  (rx_line),
        .chr   (chr),
        .valid (rx_valid)
    );

    assign rx_data    = chr.data;
    assign rx_par_err = chr.par_err;
    assign rx_frm_err = chr.frm_err;
    assign rx_brk     = chr.brk;

    assert_loop_pin_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (cfg_loop && $past(cfg_loop)) |-> txd);

    assert_seven_bit_msb_R2: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !cfg_eight_bits) |-> !rx_data[7]);

endmodule

// File: tb/test_uart_framer.sv
module test_uart_framer;
    localparam int CLK_PERIOD = 10;
    localparam int OVS_T      = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_enable = 1'b1, cfg_eight_bits = 1'b1, cfg_two_stop = 1'b0;
    logic cfg_par_en = 1'b0, cfg_loop = 1'b0, cfg_brk_req = 1'b0;
    logic [1:0] cfg_par_mode = 2'd0;
    logic [7:0] tx_data = 8'h00;
    logic tx_valid = 1'b0;
    logic tx_ready, txd, rx_valid, rx_par_err, rx_frm_err, rx_brk;
    logic rxd = 1'b1;
    logic [7:0] rx_data;

    int checks = 0;
    int fails  = 0;
    int got    = 0;
    bit done   = 0;

    typedef struct packed {
        logic [7:0] d;
        logic pe;
        logic fe;
        logic brk;
    } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_framer i_uart_framer (
        .clk(clk), .rst(rst),
        .cfg_enable(cfg_enable), .cfg_eight_bits(cfg_eight_bits),
        .cfg_two_stop(cfg_two_stop), .cfg_par_en(cfg_par_en),
        .cfg_par_mode(cfg_par_mode), .cfg_loop(cfg_loop),
        .cfg_brk_req(cfg_brk_req),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .txd(txd), .rxd(rxd),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err), .rx_brk(rx_brk)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic model_par(input logic [7:0] d);
        int ones;
        ones = $countones(cfg_eight_bits ? d : (d & 8'h7F));
        case (cfg_par_mode)
            2'd0:    return (ones % 2 == 0);
            2'd1:    return (ones % 2 == 1);
            2'd2:    return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] mask(input logic [7:0] d);
        return cfg_eight_bits ? d : (d & 8'h7F);
    endfunction

    task automatic push_exp(input logic [7:0] d, input logic pe, input logic fe,
                            input logic brk, input string tag);
        exp_q.push_back('{d: d, pe: pe, fe: fe, brk: brk});
        tag_q.push_back(tag);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            got++;
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R5 unexpected character actual=%0h expected=none", rx_data);
            end else begin
                exp_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({rx_data, rx_par_err, rx_frm_err, rx_brk} == e, t,
                      {rx_data, rx_par_err, rx_frm_err, rx_brk}, e);
            end
        end
    end

    // Transmit a byte, check every bit on txd at mid-bit and the ready timing.
    task automatic send_tx(input logic [7:0] d, input string tag);
        int nb, total, k, mism;
        logic eb[16];
        nb    = cfg_eight_bits ? 8 : 7;
        total = 1 + nb + (cfg_par_en ? 1 : 0) + (cfg_two_stop ? 2 : 1);
        eb[0] = 1'b0;
        for (int i = 0; i < nb; i++) eb[1+i] = d[i];
        k = 1 + nb;
        if (cfg_par_en) begin eb[k] = model_par(d); k++; end
        for (int i = k; i < 16; i++) eb[i] = 1'b1;
        if (cfg_loop) push_exp(mask(d), 1'b0, 1'b0, 1'b0, tag);
        @(negedge clk);
        tx_data  = d;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(posedge clk);
        #1 tx_valid = 1'b0;
        mism = 0;
        repeat (4) @(posedge clk);
        for (int b = 0; b < total; b++) begin
            if (b > 0) repeat (OVS_T) @(posedge clk);
            #1;
            if (txd !== (cfg_loop ? 1'b1 : eb[b])) mism++;
        end
        check(mism == 0, {tag, " txd frame bits"}, mism, 0);
        repeat (3) @(posedge clk);
        #1 check(tx_ready == 1'b0, "R1 ready still low before frame end", tx_ready, 0);
        @(posedge clk);
        #1 check(tx_ready == 1'b1, {tag, " ready back after frame"}, tx_ready, 1);
        repeat (4) @(negedge clk);
    endtask

    // Bit-bang a received frame on rxd (single stop bit).
    task automatic drive_rx(input logic [7:0] d, input bit flip_par, input logic stop_v,
                            input string tag);
        int nb;
        logic p;
        logic [7:0] md;
        nb = cfg_eight_bits ? 8 : 7;
        md = mask(d);
        p  = model_par(d) ^ flip_par;
        push_exp(md, cfg_par_en && flip_par, !stop_v,
                 !stop_v && md == 8'h00 && (!cfg_par_en || p == 1'b0), tag);
        @(negedge clk);
        rxd = 1'b0; repeat (OVS_T) @(negedge clk);
        for (int i = 0; i < nb; i++) begin rxd = d[i]; repeat (OVS_T) @(negedge clk); end
        if (cfg_par_en) begin rxd = p; repeat (OVS_T) @(negedge clk); end
        rxd = stop_v; repeat (OVS_T) @(negedge clk);
        rxd = 1'b1; repeat (2 * OVS_T) @(negedge clk);
        check(exp_q.size() == 0, {tag, " character delivered"}, exp_q.size(), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Reset state
        check(tx_ready == 1'b1 && txd == 1'b1 && rx_valid == 1'b0,
              "R1 reset idle state", {tx_ready, txd, rx_valid}, 3'b110);

        // R1 / R5: 8N1 transmit and receive
        send_tx(8'hA5, "R1 8N1");
        drive_rx(8'h3C, 0, 1'b1, "R5 8N1 receive");
        drive_rx(8'hFF, 0, 1'b1, "R5 all ones");

        // R2: 7-bit mode
        cfg_eight_bits = 1'b0;
        send_tx(8'hD3, "R2 seven-bit tx");
        drive_rx(8'hD5, 0, 1'b1, "R2 seven-bit rx masks bit7");
        cfg_eight_bits = 1'b1;

        // R3: parity modes, via transmit pin and via loopback
        cfg_par_en = 1'b1;
        for (int m = 0; m < 4; m++) begin
            cfg_par_mode = 2'(m);
            send_tx(8'h31, "R3 parity mode tx");
            drive_rx(8'h6B, 0, 1'b1, "R3 parity mode rx");
        end

        // R7: parity error in each mode
        for (int m = 0; m < 4; m++) begin
            cfg_par_mode = 2'(m);
            drive_rx(8'h0F, 1, 1'b1, "R7 parity error");
        end

        // R4: two stop bits on transmit, receiver still accepts one
        cfg_par_mode = 2'd1;
        cfg_two_stop = 1'b1;
        send_tx(8'h5A, "R4 two stop tx");
        drive_rx(8'h81, 0, 1'b1, "R4 rx single stop");
        cfg_two_stop = 1'b0;

        // R8: framing error with non-zero data
        drive_rx(8'h42, 0, 1'b0, "R8 framing error");

        // R9: line held low through a whole character (even parity -> parity bit 0 ok)
        push_exp(8'h00, 1'b0, 1'b1, 1'b1, "R9 break with parity");
        @(negedge clk);
        rxd = 1'b0; repeat (OVS_T * 11) @(negedge clk);
        rxd = 1'b1; repeat (OVS_T * 3) @(negedge clk);
        check(exp_q.size() == 0, "R9 break delivered", exp_q.size(), 0);
        cfg_par_en = 1'b0;
        push_exp(8'h00, 1'b0, 1'b1, 1'b1, "R9 break no parity");
        @(negedge clk);
        rxd = 1'b0; repeat (OVS_T * 10) @(negedge clk);
        rxd = 1'b1; repeat (OVS_T * 3) @(negedge clk);
        check(exp_q.size() == 0, "R9 break delivered", exp_q.size(), 0);

        // R6: short glitch
        begin
            int g0;
            g0 = got;
            @(negedge clk);
            rxd = 1'b0; repeat (2) @(negedge clk);
            rxd = 1'b1; repeat (OVS_T * 12) @(negedge clk);
            check(got == g0, "R6 glitch rejected", got - g0, 0);
        end
        drive_rx(8'hC3, 0, 1'b1, "R6 clean frame after glitch");

        // R10: loopback, pin stays high, receiver gets the byte
        cfg_loop = 1'b1;
        repeat (2) @(negedge clk);
        send_tx(8'h96, "R10 loopback");
        cfg_par_en = 1'b1; cfg_par_mode = 2'd3;
        send_tx(8'h7E, "R10 loopback mark parity");
        check(exp_q.size() == 0, "R10 loopback characters received", exp_q.size(), 0);
        cfg_par_en = 1'b0;
        cfg_loop = 1'b0;
        repeat (4) @(negedge clk);

        // R11: break request
        cfg_brk_req = 1'b1;
        repeat (3) @(negedge clk);
        check(txd == 1'b0, "R11 break holds txd low", txd, 0);
        repeat (20) @(negedge clk);
        check(txd == 1'b0, "R11 break still low", txd, 0);
        cfg_brk_req = 1'b0;
        @(negedge clk);
        check(txd == 1'b1, "R11 released", txd, 1);

        // R12: disabled framer
        cfg_enable = 1'b0;
        tx_valid = 1'b1;
        tx_data  = 8'h11;
        repeat (3) @(negedge clk);
        check(tx_ready == 1'b0 && txd == 1'b1, "R12 disabled tx idle", {tx_ready, txd}, 2'b01);
        tx_valid = 1'b0;
        begin
            int g1;
            g1 = got;
            rxd = 1'b0; repeat (OVS_T * 4) @(negedge clk);
            rxd = 1'b1; repeat (OVS_T * 8) @(negedge clk);
            check(got == g1, "R12 disabled rx silent", got - g1, 0);
        end
        cfg_enable = 1'b1;
        repeat (4) @(negedge clk);
        drive_rx(8'h99, 0, 1'b1, "R12 re-enabled receive");

        check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule